// File: doc/BRIEF.md
# Interrupt Snapshot Register Unit

This block merges the interrupt requests of four serial channels. Each channel raises up to six kinds of request. An active-low interrupt line is driven low at once whenever any request is pending. The block also selects the single most urgent request. It uses a fixed ranking of request kinds, and the lowest channel number wins a tie.

The selected request is not visible to the host straight away. It is copied into an 8-bit read-only snapshot register only when one of two events occurs: an interrupt acknowledge (a falling edge on the acknowledge input, synchronised to the clock), or a host write to the update address. A host may therefore take the request line at any time and still read a stable, coherent description later.

The snapshot holds three fields. The 3-bit count field carries a receive fill level or a transmit free space, depending on the request kind, and it saturates at 7. The other two fields are the 3-bit kind code and the 2-bit channel number.

Top module: `irqs_top`

## Requirements
- R1: A read strobe at address 0x28 loads `rd_data` on that clock edge with the snapshot. Bits 7:5 hold the count, bits 4:2 the kind code and bits 1:0 the channel. An edge that also captures still returns the older snapshot.
- R2: Kind codes are 000 none, 001 status change, 010 transmit space, 011 receive data, 100 break change, 101 timer and 111 receive data with errors.
- R3: Kinds rank from highest to lowest as follows: receive with errors, receive, break change, transmit space, timer, status change.
- R4: When two or more channels raise the winning kind, the lowest channel number is taken.
- R5: For kinds 011 and 111 the count field is that channel's receive level. For kind 010 it is that channel's transmit free space. Both saturate at 7. For every other kind the count field is 000.
- R6: `irq_n` is low in the same cycle that any request input is high, and high when none is.
- R7: A write strobe at address 0x2A captures the current selection into the snapshot on that clock edge.
- R8: A falling edge of `iack_n` captures the selection two clock edges after the first edge that samples it low. A rising edge of `iack_n` captures nothing.
- R9: The snapshot is all zeros after reset. Request changes and the assertion of `irq_n` never alter it.
- R10: A read at any address other than 0x28 returns 0x00. A write at any address other than 0x2A does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Registered read data |
| iack_n | input | 1 | Interrupt acknowledge, active low, asynchronous |
| req_rxe | input | 4 | Per-channel receive-with-errors request |
| req_rxo | input | 4 | Per-channel receive request |
| req_brk | input | 4 | Per-channel break-change request |
| req_tx | input | 4 | Per-channel transmit-space request |
| req_tmr | input | 4 | Per-channel timer request |
| req_cos | input | 4 | Per-channel status-change request |
| rx_level | input | 24 | Per-channel receive fill level, 6 bits each |
| tx_space | input | 24 | Per-channel transmit free space, 6 bits each |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Requests are added one kind at a time. Each new kind outranks the one before it, so every step of the ranking is observed through the snapshot. Two channels raise the same kind to show the tie rule. Count inputs of 20, 9, 3 and 5 separate the saturated case from the pass-through case, and they also show whether the receive or the transmit count was routed. Reads taken after request changes, after the acknowledge is released, and after writes to other addresses show that only the two defined events capture.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int NCLS = 6;
  localparam int CH_W = 2;

  typedef enum logic [2:0] {
    K_NONE  = 3'b000,
    K_COS   = 3'b001,
    K_TX    = 3'b010,
    K_RXOK  = 3'b011,
    K_BRK   = 3'b100,
    K_TMR   = 3'b101,
    K_RXERR = 3'b111
  } kind_e;

  typedef struct packed {
    logic [2:0]      cnt;
    kind_e           kind;
    logic [CH_W-1:0] ch;
  } snap_t;

  // rank position -> kind code, index 0 is most urgent
  function automatic kind_e rank_kind(input int r);
    case (r)
      0:       return K_RXERR;
      1:       return K_RXOK;
      2:       return K_BRK;
      3:       return K_TX;
      4:       return K_TMR;
      default: return K_COS;
    endcase
  endfunction
endpackage

// File: rtl/irqs_prio.sv
module irqs_prio
  import irqs_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       req_rxe,
  input  logic [NCH-1:0]       req_rxo,
  input  logic [NCH-1:0]       req_brk,
  input  logic [NCH-1:0]       req_tx,
  input  logic [NCH-1:0]       req_tmr,
  input  logic [NCH-1:0]       req_cos,
  input  logic [NCH*CNT_W-1:0] rx_level,
  input  logic [NCH*CNT_W-1:0] tx_space,
  output snap_t                sel,
  output logic                 any_req
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(7);

  logic [NCLS-1:0][NCH-1:0] cls;
  logic [CNT_W-1:0]         lvl;
  logic                     hit;
  int                       pick;

  assign cls = {req_cos, req_tmr, req_tx, req_brk, req_rxo, req_rxe};
  assign any_req = |{req_rxe, req_rxo, req_brk, req_tx, req_tmr, req_cos};

  always_comb begin
    sel  = '0;
    hit  = 1'b0;
    pick = 0;
    lvl  = '0;
    for (int r = 0; r < NCLS; r++) begin
      for (int k = 0; k < NCH; k++) begin
        if (!hit && cls[r][k]) begin
          hit      = 1'b1;
          pick     = k;
          sel.kind = rank_kind(r);
          sel.ch   = CH_W'(k);
        end
      end
    end
    if (sel.kind == K_RXOK || sel.kind == K_RXERR)
      lvl = rx_level[pick*CNT_W +: CNT_W];
    else if (sel.kind == K_TX)
      lvl = tx_space[pick*CNT_W +: CNT_W];
    sel.cnt = (lvl > SAT) ? 3'd7 : lvl[2:0];
  end

  // R6: the request summary and the ranked choice agree
  a_r6_any_matches: assert property (@(posedge clk) disable iff (rst)
    any_req == (sel.kind != K_NONE));
  // R4: chosen channel really raises a request
  a_r4_chan_valid: assert property (@(posedge clk) disable iff (rst)
    (sel.kind != K_NONE) |-> |(cls[0][sel.ch] | cls[1][sel.ch] | cls[2][sel.ch] |
                               cls[3][sel.ch] | cls[4][sel.ch] | cls[5][sel.ch]));
endmodule

// File: rtl/irqs_ack_sync.sv
module irqs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic iack_n,
  output logic ack_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], iack_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ack_fall = last_q & ~sync_q[STAGES-1];

  // R8: one capture pulse per acknowledge edge
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ack_fall |=> !ack_fall);
endmodule

// File: rtl/irqs_snap.sv
module irqs_snap
  import irqs_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  SNAP_ADDR = 8'h28,
  parameter logic [7:0]  UPD_ADDR  = 8'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              ack_fall,
  input  snap_t             sel,
  output logic [7:0]        rd_data
);
  snap_t snap_q;
  logic  cap;

  assign cap = ack_fall | (wr_en && addr == ADDR_W'(UPD_ADDR));

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (cap) snap_q <= sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= (addr == ADDR_W'(SNAP_ADDR)) ? snap_q : 8'h00;
  end

  // R7: a capture edge loads the selection seen at that edge
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    cap |=> snap_q == $past(sel));
  // R9: without a capture event the snapshot holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap_q));
  // R1: reads at the snapshot address return the pre-edge snapshot
  a_r1_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(SNAP_ADDR)) |=> rd_data == $past(snap_q));
  // R10: other read addresses return zero
  a_r10_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(SNAP_ADDR)) |=> rd_data == 8'h00);
endmodule

// File: rtl/irqs_top.sv
module irqs_top
  import irqs_pkg::*;
#(
  parameter int         NCH       = 4,
  parameter int         CNT_W     = 6,
  parameter int         ADDR_W    = 8,
  parameter int         SYNC_N    = 2,
  parameter logic [7:0] SNAP_ADDR = 8'h28,
  parameter logic [7:0] UPD_ADDR  = 8'h2A
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  output logic [7:0]           rd_data,
  input  logic                 iack_n,
  input  logic [NCH-1:0]       req_rxe,
  input  logic [NCH-1:0]       req_rxo,
  input  logic [NCH-1:0]       req_brk,
  input  logic [NCH-1:0]       req_tx,
  input  logic [NCH-1:0]       req_tmr,
  input  logic [NCH-1:0]       req_cos,
  input  logic [NCH*CNT_W-1:0] rx_level,
  input  logic [NCH*CNT_W-1:0] tx_space,
  output logic                 irq_n
);
  snap_t sel;
  logic  any_req;
  logic  ack_fall;

  irqs_prio #(.NCH(NCH), .CNT_W(CNT_W)) u_prio (
    .clk(clk), .rst(rst),
    .req_rxe(req_rxe), .req_rxo(req_rxo), .req_brk(req_brk),
    .req_tx(req_tx), .req_tmr(req_tmr), .req_cos(req_cos),
    .rx_level(rx_level), .tx_space(tx_space),
    .sel(sel), .any_req(any_req)
  );

  irqs_ack_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .iack_n(iack_n), .ack_fall(ack_fall)
  );

  irqs_snap #(.ADDR_W(ADDR_W), .SNAP_ADDR(SNAP_ADDR), .UPD_ADDR(UPD_ADDR)) u_snap (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .ack_fall(ack_fall), .sel(sel), .rd_data(rd_data)
  );

  assign irq_n = ~any_req;
endmodule

// File: tb/test_irqs_top.sv
module test_irqs_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = '0;
  logic        rd_en = 0, wr_en = 0, iack_n = 1;
  logic [3:0]  req_rxe = 0, req_rxo = 0, req_brk = 0, req_tx = 0, req_tmr = 0, req_cos = 0;
  logic [23:0] rx_level = 0, tx_space = 0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0, errors = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  irqs_top i_irqs_top (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .iack_n(iack_n),
    .req_rxe(req_rxe), .req_rxo(req_rxo), .req_brk(req_brk),
    .req_tx(req_tx), .req_tmr(req_tmr), .req_cos(req_cos),
    .rx_level(rx_level), .tx_space(tx_space), .irq_n(irq_n)
  );

  always #2 clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare read data one half cycle after the read edge
  initial forever begin
    @(negedge clk);
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a);
    addr = a; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    #0.5;
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n %b expected %b", t, irq_n, e);
    end
  endtask

  function automatic logic [7:0] pack(input int cnt, input logic [2:0] k, input int ch);
    return {3'(cnt), k, 2'(ch)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_irq(1'b1, "R6 idle");
    do_read(8'h28, 8'h00, "R9 reset snapshot");

    req_cos[2] = 1;
    chk_irq(1'b0, "R6 request");
    @(negedge clk);
    do_read(8'h28, 8'h00, "R9 no load on irq");
    do_write(8'h2A);
    do_read(8'h28, pack(0, 3'b001, 2), "R7 R2 status change");

    req_tmr[3] = 1; do_write(8'h2A);
    do_read(8'h28, pack(0, 3'b101, 3), "R3 timer over status");

    req_tx[1] = 1; tx_space[6 +: 6] = 6'd20; do_write(8'h2A);
    do_read(8'h28, pack(7, 3'b010, 1), "R5 R3 tx saturated");

    req_brk[3] = 1; do_write(8'h2A);
    do_read(8'h28, pack(0, 3'b100, 3), "R3 break over tx");

    req_rxo[2] = 1; req_rxo[1] = 1; rx_level[6 +: 6] = 6'd5; rx_level[12 +: 6] = 6'd3;
    do_write(8'h2A);
    do_read(8'h28, pack(5, 3'b011, 1), "R4 R5 lowest channel rx");

    req_rxe[3] = 1; rx_level[18 +: 6] = 6'd9;
    @(negedge clk);
    do_read(8'h28, pack(5, 3'b011, 1), "R9 request change no load");
    iack_n = 0;
    repeat (2) @(negedge clk);
    do_read(8'h28, pack(5, 3'b011, 1), "R8 not before sync");
    repeat (2) @(negedge clk);
    do_read(8'h28, pack(7, 3'b111, 3), "R8 R3 ack capture");

    req_rxe = 0; req_rxo = 0; req_brk = 0; req_tx = 0; req_tmr = 0; req_cos = 0;
    chk_irq(1'b1, "R6 cleared");
    iack_n = 1;
    repeat (5) @(negedge clk);
    do_read(8'h28, pack(7, 3'b111, 3), "R8 release no capture");
    do_write(8'h28);
    do_write(8'h29);
    do_read(8'h28, pack(7, 3'b111, 3), "R10 other write ignored");
    do_read(8'h27, 8'h00, "R10 other read zero");
    do_write(8'h2A);
    do_read(8'h28, 8'h00, "R2 R1 none after update");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: expired expected completion");
      end
    join_any
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d left expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule